// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller watches nineteen input lines and turns selected transitions on them into interrupt and event requests. Sixteen of the lines come from general-purpose pins. Each of these lines has a port selector that chooses which of five ports supplies the pin with the same index. The last three lines come from internal sources. Each line has its own rising-edge and falling-edge enables. Any edge that is enabled is caught by a flop clocked by the line itself, so a pulse shorter than a bus clock period is still seen. The caught flag passes through a two-flop synchronizer into the bus clock domain, and a clocked acknowledge then releases the catch flop.

A sticky pending register records every line that has fired. Software clears a bit by writing 1 to it, and can also raise pending bits directly through a software-trigger register. The interrupt output is the OR of the pending bits whose line is unmasked. A separate event mask produces a one-cycle event pulse per line.

Configuration uses a small register interface with one address bus and write-data, write-enable and combinational read-data signals. The register map is:

| Address | Contents |
|---|---|
| 0 | Interrupt enable, one bit per line |
| 1 | Event enable, one bit per line |
| 2 | Rising-edge enable, one bit per line |
| 3 | Falling-edge enable, one bit per line |
| 4 | Software trigger, write 1 per line; always reads 0 |
| 5 | Pending, write 1 to clear |
| 8+n | Port select for GPIO line n (n = 0..15), in bits [2:0] |

Top module: `eic_top`

## Requirements
- R1: After reset, all registers read 0. `irq` is 0, `evt` is 0, and every GPIO line selects port 0.
- R2: With the rising enable set, a 0-to-1 transition on a line sets its pending bit. With the falling enable set, a 1-to-0 transition sets it. The bit is set within four bus clock edges of the transition.
- R3: With both edge enables of a line cleared, no transition on that line sets its pending bit.
- R4: An enabled edge is latched even when the pulse begins and ends between two rising bus clock edges.
- R5: Pending bits stay set until cleared. Writing 1 to a bit at address 5 clears that bit. Writing 0 to a bit leaves it unchanged.
- R6: If an edge reaches the pending register in the same cycle that a clear of that bit is written, the bit stays set.
- R7: `irq` is 1 exactly when some pending bit has its interrupt enable set. A masked line still records its pending bit but does not raise `irq`.
- R8: When a line's event enable is set, each detection on that line gives exactly one cycle of `evt[n]`, whatever the line's interrupt enable is. With the event enable cleared, `evt[n]` stays 0.
- R9: Writing 1 to bit n of address 4 sets pending bit n and gives an event pulse, just as a detected edge does. Address 4 always reads 0.
- R10: GPIO line n follows `gpio_pins[p*16+n]`, where p is its port select value. Pins of other ports have no effect on the line. A select value of 5 or more holds the line at 0.
- R11: Lines 16 to 18 are driven by `int_src[0]` to `int_src[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_pins | input | 80 | Pins of five ports; port p pin n is at bit p*16+n |
| int_src | input | 3 | Internal sources for lines 16 to 18 |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | OR of unmasked pending bits |
| evt | output | 19 | One-cycle event pulse per line |

## Verification
The hardest case to reach from the ports is an edge reaching the pending register in exactly the same cycle as a clear write to that bit. The bench starts from the number of synchronizer stages. It raises the pin just after a falling clock edge, then presents the clear write two falling edges later, so that both land on the same rising edge. The sub-period pulse for R4 is made by toggling a pin high and low inside the low half of a clock cycle, so that no rising clock edge ever sees it high.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_IEN  = 5'd0,
    A_EEN  = 5'd1,
    A_RISE = 5'd2,
    A_FALL = 5'd3,
    A_SWT  = 5'd4,
    A_PEND = 5'd5,
    A_SEL0 = 5'd8
  } reg_addr_e;

  typedef logic [DATA_W-1:0] word_t;

  // new pending state: clears applied first, sets win
  function automatic word_t pend_update(word_t cur, word_t clr, word_t set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/eic_port_mux.sv
module eic_port_mux #(
  parameter int NUM_PORTS = 5,
  parameter int NUM_GPIO  = 16,
  parameter int SEL_W     = 3
) (
  input  logic [NUM_PORTS*NUM_GPIO-1:0] pins,
  input  logic [NUM_GPIO*SEL_W-1:0]     sel_flat,
  output logic [NUM_GPIO-1:0]           lines
);
  for (genvar n = 0; n < NUM_GPIO; n++) begin : g_line
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      lines[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (sel == SEL_W'(p)) lines[n] = pins[p*NUM_GPIO+n];
    end
  end
endmodule

// File: rtl/eic_edge_catch.sv
module eic_edge_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit
);
  logic cap_r, cap_f, s1, s2, s3, rel;

  // acknowledge from the clock domain releases the catch flops
  assign rel = s2 | ~rst_n;

  always_ff @(posedge line_in or posedge rel)
    if (rel) cap_r <= 1'b0;
    else     cap_r <= rise_en;

  always_ff @(negedge line_in or posedge rel)
    if (rel) cap_f <= 1'b0;
    else     cap_f <= fall_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= cap_r | cap_f;
      s2 <= s1;
      s3 <= s2;
    end

  assign hit = s2 & ~s3;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int NUM_GPIO  = 16,
  parameter int SEL_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NUM_LINES-1:0]      hit,
  output logic [NUM_LINES-1:0]      ien,
  output logic [NUM_LINES-1:0]      een,
  output logic [NUM_LINES-1:0]      rise,
  output logic [NUM_LINES-1:0]      fall,
  output logic [NUM_GPIO*SEL_W-1:0] sel_flat,
  output logic [NUM_LINES-1:0]      pend,
  output logic [NUM_LINES-1:0]      evt,
  output logic [NUM_LINES-1:0]      set_vec,
  output logic [NUM_LINES-1:0]      clr_vec
);
  logic [SEL_W-1:0] sel_r [NUM_GPIO];
  logic [NUM_LINES-1:0] wdat;
  word_t pend_nx;

  assign wdat    = reg_wdata[NUM_LINES-1:0];
  assign set_vec = hit | ((reg_wr && reg_addr == A_SWT) ? wdat : '0);
  assign clr_vec = (reg_wr && reg_addr == A_PEND) ? wdat : '0;
  assign pend_nx = pend_update(DATA_W'(pend), DATA_W'(clr_vec), DATA_W'(set_vec));

  for (genvar n = 0; n < NUM_GPIO; n++) begin : g_sel
    assign sel_flat[n*SEL_W +: SEL_W] = sel_r[n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien  <= '0;
      een  <= '0;
      rise <= '0;
      fall <= '0;
      pend <= '0;
      evt  <= '0;
      for (int n = 0; n < NUM_GPIO; n++) sel_r[n] <= '0;
    end else begin
      pend <= pend_nx[NUM_LINES-1:0];
      evt  <= set_vec & een;
      if (reg_wr) begin
        case (reg_addr)
          A_IEN:   ien  <= wdat;
          A_EEN:   een  <= wdat;
          A_RISE:  rise <= wdat;
          A_FALL:  fall <= wdat;
          default: ;
        endcase
        for (int n = 0; n < NUM_GPIO; n++)
          if (reg_addr == ADDR_W'(A_SEL0 + n)) sel_r[n] <= reg_wdata[SEL_W-1:0];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_IEN:   reg_rdata = DATA_W'(ien);
      A_EEN:   reg_rdata = DATA_W'(een);
      A_RISE:  reg_rdata = DATA_W'(rise);
      A_FALL:  reg_rdata = DATA_W'(fall);
      A_PEND:  reg_rdata = DATA_W'(pend);
      default: ;
    endcase
    for (int n = 0; n < NUM_GPIO; n++)
      if (reg_addr == ADDR_W'(A_SEL0 + n)) reg_rdata = DATA_W'(sel_r[n]);
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int NUM_GPIO  = 16,
  parameter int NUM_PORTS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*NUM_GPIO-1:0] gpio_pins,
  input  logic [NUM_LINES-NUM_GPIO-1:0] int_src,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          irq,
  output logic [NUM_LINES-1:0]          evt
);
  localparam int SEL_W = $clog2(NUM_PORTS) > 0 ? $clog2(NUM_PORTS) : 1;

  logic [NUM_GPIO*SEL_W-1:0] sel_flat;
  logic [NUM_GPIO-1:0]       gpio_lines;
  logic [NUM_LINES-1:0]      lines, hit, ien, een, rise, fall, pend, set_vec, clr_vec;

  eic_port_mux #(.NUM_PORTS(NUM_PORTS), .NUM_GPIO(NUM_GPIO), .SEL_W(SEL_W)) u_mux (
    .pins(gpio_pins), .sel_flat(sel_flat), .lines(gpio_lines)
  );

  assign lines = {int_src, gpio_lines};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_catch
    eic_edge_catch u_catch (
      .clk(clk), .rst_n(rst_n), .line_in(lines[i]),
      .rise_en(rise[i]), .fall_en(fall[i]), .hit(hit[i])
    );
  end

  eic_regs #(.NUM_LINES(NUM_LINES), .NUM_GPIO(NUM_GPIO), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit),
    .ien(ien), .een(een), .rise(rise), .fall(fall), .sel_flat(sel_flat),
    .pend(pend), .evt(evt), .set_vec(set_vec), .clr_vec(clr_vec)
  );

  assign irq = |(pend & ien);
endmodule

// File: rtl/eic_top_chk.sv
module eic_top_chk #(
  parameter int NUM_LINES = 19
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] hit,
  input logic [NUM_LINES-1:0] set_vec,
  input logic [NUM_LINES-1:0] clr_vec,
  input logic [NUM_LINES-1:0] evt,
  input logic [NUM_LINES-1:0] een
);
  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr_vec)) == '0));

  assert_pend_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend & ~$past(pend)) & ~$past(set_vec)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~pend) == '0));

  assert_irq_has_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

  assert_hit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit & $past(hit)) == '0));

  assert_evt_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(een)) == '0));
endmodule

bind eic_top eic_top_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend), .hit(hit),
  .set_vec(set_vec), .clr_vec(clr_vec), .evt(evt), .een(een)
);

// File: tb/eic_top_test.sv
module eic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] gpio_pins = '0;
  logic [2:0]  int_src = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [18:0] evt;

  int total = 0;
  int bad = 0;
  int evt_cnt [19];

  eic_top uut (
    .clk(clk), .rst_n(rst_n), .gpio_pins(gpio_pins), .int_src(int_src),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .evt(evt)
  );

  always #5 clk = ~clk;

  initial for (int i = 0; i < 19; i++) evt_cnt[i] = 0;
  always @(negedge clk)
    for (int i = 0; i < 19; i++) if (evt[i]) evt_cnt[i] = evt_cnt[i] + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    gpio_pins[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_all();
    wr(5'd5, 32'h7FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(5'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    rd(5'd11, d);
    chk("R1 sel", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 evt", {13'h0, evt}, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(5'd2, 32'h1);
    set_pin(0, 1'b1);
    rd(5'd5, d); chk("R2 rise", d, 32'h1);
    chk("R7 masked irq", {31'h0, irq}, 32'h0);
    wr(5'd0, 32'h1);
    #1 chk("R7 unmasked irq", {31'h0, irq}, 32'h1);
    wr(5'd5, 32'h0);
    rd(5'd5, d); chk("R5 write 0 keeps", d, 32'h1);
    wr(5'd5, 32'h1);
    rd(5'd5, d); chk("R5 w1c", d, 32'h0);
    chk("R7 irq drops", {31'h0, irq}, 32'h0);
    wr(5'd2, 32'h0);
    wr(5'd3, 32'h1);
    set_pin(0, 1'b0);
    rd(5'd5, d); chk("R2 fall", d, 32'h1);
    clr_all();
    set_pin(0, 1'b1);
    rd(5'd5, d); chk("R2 rise ignored with fall only", d, 32'h0);
    wr(5'd0, 32'h0);
    wr(5'd3, 32'h0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    clr_all();
    set_pin(1, 1'b1);
    set_pin(1, 1'b0);
    rd(5'd5, d); chk("R3 no enables", d, 32'h0);
  endtask

  task automatic t_short();
    logic [31:0] d;
    clr_all();
    wr(5'd2, 32'h4);
    @(negedge clk);
    #1 gpio_pins[2] = 1'b1;
    #2 gpio_pins[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5'd5, d); chk("R4 short pulse", d, 32'h4);
  endtask

  task automatic t_mux();
    logic [31:0] d;
    clr_all();
    wr(5'd2, 32'h8);
    wr(5'd11, 32'h2);
    rd(5'd11, d); chk("R10 sel readback", d, 32'h2);
    set_pin(3, 1'b1);
    rd(5'd5, d); chk("R10 other port ignored", d, 32'h0);
    set_pin(35, 1'b1);
    rd(5'd5, d); chk("R10 selected port", d, 32'h8);
    clr_all();
    set_pin(35, 1'b0);
    wr(5'd11, 32'h7);
    set_pin(35, 1'b1);
    rd(5'd5, d); chk("R10 sel out of range", d, 32'h0);
    set_pin(3, 1'b0);
    set_pin(35, 1'b0);
  endtask

  task automatic t_internal();
    logic [31:0] d;
    clr_all();
    wr(5'd2, 32'h20000);
    @(negedge clk);
    int_src[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'd5, d); chk("R11 internal line 17", d, 32'h20000);
  endtask

  task automatic t_event();
    logic [31:0] d;
    int c0;
    clr_all();
    wr(5'd0, 32'h0);
    wr(5'd1, 32'h20);
    wr(5'd2, 32'h20);
    #1 c0 = evt_cnt[5];
    set_pin(5, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R8 one event pulse", 32'(evt_cnt[5] - c0), 32'h1);
    chk("R8 event with int masked", {31'h0, irq}, 32'h0);
    wr(5'd1, 32'h0);
    set_pin(5, 1'b0);
    #1 c0 = evt_cnt[5];
    set_pin(5, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R8 event disabled", 32'(evt_cnt[5] - c0), 32'h0);
    set_pin(5, 1'b0);
  endtask

  task automatic t_swtrig();
    logic [31:0] d;
    int c0;
    clr_all();
    wr(5'd1, 32'h40000);
    #1 c0 = evt_cnt[18];
    wr(5'd4, 32'h40000);
    repeat (3) @(negedge clk);
    rd(5'd5, d); chk("R9 swtrig sets pending", d, 32'h40000);
    #1 chk("R9 swtrig event", 32'(evt_cnt[18] - c0), 32'h1);
    rd(5'd4, d); chk("R9 swtrig reads 0", d, 32'h0);
    wr(5'd1, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    clr_all();
    wr(5'd2, 32'h40);
    wr(5'd4, 32'h40);
    @(negedge clk);
    gpio_pins[6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 5'd5; reg_wdata = 32'h40; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(5'd5, d); chk("R6 set wins over clear", d, 32'h40);
    wr(5'd5, 32'h40);
    rd(5'd5, d); chk("R6 later clear works", d, 32'h0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_none();
    t_short();
    t_mux();
    t_internal();
    t_event();
    t_swtrig();
    t_setwins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule